// File: doc/BRIEF.md
# Fast-Clear Resolve Sequencer

This block turns a fast-cleared color surface back into a plain one. A small auxiliary store keeps one code per block of the main surface, and each block covers two 64-byte lines. A code of all ones means the block has never been written since the last fast clear, so its real contents are the clear color, not what sits in main memory.

After a one-cycle start pulse, the sequencer visits every aux entry in ascending index order. For each entry holding the clear code, it writes the clear color into both lines of the matching block through a valid/ready write port. Every entry is then rewritten to zero, the pass-through code. When the walk is over, main memory alone holds the true image and the aux store can be ignored.

The aux store is an external synchronous RAM with a one-cycle read latency. The code width is a parameter: one bit, or two bits where only code 3 means clear. The block count is also a parameter, and it may be zero.

Top module: `fast_clear_resolver`

## Requirements
- R1: After an accepted start, the aux entries are read exactly once each, at indices 0, 1, ..., NUM_BLOCKS-1 in ascending order. Read data arrives in the cycle after `auxRe`.
- R2: An entry whose code is all ones (1 when AUX_W=1, 3 when AUX_W=2) causes exactly two write beats. Each beat's data is the latched clear color repeated across all LINE_BITS.
- R3: An entry with any other code causes no main-memory write.
- R4: Every aux entry is written with 0 (pass-through) during the walk, so the whole aux store reads 0 once `done` has pulsed.
- R5: The beats of block i go to byte addresses i*128 and then i*128+64, low line first. Blocks are written in ascending index order.
- R6: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memData` hold their values. No beat is dropped or reordered.
- R7: `done` is high for exactly one cycle, in the cycle right after the cycle with the last aux write. `busy` is high from the cycle after an accepted start until that `done` cycle, inclusive, and low afterwards.
- R8: A start pulse while `busy` is high is ignored: no second walk happens and no extra writes appear.
- R9: The clear color is sampled in the cycle start is accepted. Later changes of `clearColor` during the walk do not change the written data.
- R10: With NUM_BLOCKS=0, `done` pulses in the cycle after start is accepted, and no aux or memory access is made.
- R11: With AUX_W=2, codes 1 and 2 count as not clear (R3 applies) but are still rewritten to 0 (R4 applies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only when idle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| clearColor | input | COLOR_W | Clear color, sampled at start |
| auxAddr | output | IDX_W | Aux entry index for read or write |
| auxRe | output | 1 | Aux read strobe, data returned next cycle |
| auxRdata | input | AUX_W | Aux read data |
| auxWe | output | 1 | Aux write strobe |
| auxWdata | output | AUX_W | Aux write data (pass-through code) |
| memValid | output | 1 | Main-memory write beat valid |
| memReady | input | 1 | Main-memory write beat accepted |
| memAddr | output | IDX_W+7 | Byte address of the 64-byte line |
| memData | output | LINE_BITS | Line data |

## Verification
Only one access port can be active in a cycle. What overlaps in time is write backpressure on the second line of a clear block and a stray start pulse or a clear-color change. The bench drives a ready pattern that stalls two of every three cycles. While beats are stalled, it changes `clearColor` and pulses `start` again. Each beat's address and data are compared with the values held before the stall, the data with the color sampled at the first start. The bench also checks that exactly one `done` pulse appears, right after the last aux write.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_LINE_LO,
    ST_LINE_HI,
    ST_AUX_WR,
    ST_FINISH
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic idxClear;
    logic idxStep;
    logic colorLoad;
    logic lineHigh;
  } dpCtrl_t;

endpackage

// File: rtl/fcr_control.sv
module fcr_control
  import fcr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    blockClear,
  input  logic    idxLast,
  input  logic    memReady,
  output dpCtrl_t ctrl,
  output logic    auxRe,
  output logic    auxWe,
  output logic    memValid,
  output logic    busy,
  output logic    done
);

  localparam bit IS_EMPTY = (NUM_BLOCKS == 0);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    auxRe     = 1'b0;
    auxWe     = 1'b0;
    memValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.idxClear  = 1'b1;
          ctrl.colorLoad = 1'b1;
          stateNext      = IS_EMPTY ? ST_FINISH : ST_READ;
        end
      end
      ST_READ: begin
        auxRe     = 1'b1;
        stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        stateNext = blockClear ? ST_LINE_LO : ST_AUX_WR;
      end
      ST_LINE_LO: begin
        memValid = 1'b1;
        if (memReady) stateNext = ST_LINE_HI;
      end
      ST_LINE_HI: begin
        memValid      = 1'b1;
        ctrl.lineHigh = 1'b1;
        if (memReady) stateNext = ST_AUX_WR;
      end
      ST_AUX_WR: begin
        auxWe = 1'b1;
        if (idxLast) begin
          stateNext = ST_FINISH;
        end else begin
          ctrl.idxStep = 1'b1;
          stateNext    = ST_READ;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a beat that is not taken is still offered next cycle
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);

  // R6: aux and memory accesses never share a cycle
  p_single_access_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({auxRe, auxWe, memValid}));

endmodule

// File: rtl/fcr_datapath.sv
module fcr_datapath
  import fcr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int AUX_W      = 2,
  parameter int COLOR_W    = 32,
  parameter int LINE_BITS  = 512,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  parameter int LINE_OFS_W = $clog2(LINE_BITS / 8),
  parameter int MEM_ADDR_W = IDX_W + 1 + LINE_OFS_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  logic [AUX_W-1:0]      auxRdata,
  input  logic [COLOR_W-1:0]    clearColor,
  output logic                  blockClear,
  output logic                  idxLast,
  output logic [IDX_W-1:0]      auxAddr,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [LINE_BITS-1:0]  memData
);

  localparam int              REPEAT     = LINE_BITS / COLOR_W;
  localparam logic [AUX_W-1:0] CLEAR_CODE = {AUX_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_IDX   =
    IDX_W'((NUM_BLOCKS > 0) ? (NUM_BLOCKS - 1) : 0);

  logic [IDX_W-1:0]   blockIdx;
  logic [COLOR_W-1:0] colorReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              blockIdx <= '0;
    else if (ctrl.idxClear) blockIdx <= '0;
    else if (ctrl.idxStep)  blockIdx <= blockIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               colorReg <= '0;
    else if (ctrl.colorLoad) colorReg <= clearColor;
  end

  for (genvar g = 0; g < REPEAT; g++) begin : g_fill
    assign memData[g*COLOR_W +: COLOR_W] = colorReg;
  end

  assign blockClear = (auxRdata == CLEAR_CODE);
  assign idxLast    = (blockIdx == LAST_IDX);
  assign auxAddr    = blockIdx;
  assign memAddr    = {blockIdx, ctrl.lineHigh, {LINE_OFS_W{1'b0}}};

  // R1: the walk never leaves the index range
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    blockIdx <= LAST_IDX);

  // R1: indices advance by exactly one
  p_idx_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.idxStep |=> (blockIdx == $past(blockIdx) + 1'b1));

endmodule

// File: rtl/fast_clear_resolver.sv
module fast_clear_resolver
  import fcr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int AUX_W      = 2,
  parameter int COLOR_W    = 32,
  parameter int LINE_BITS  = 512,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  parameter int LINE_OFS_W = $clog2(LINE_BITS / 8),
  parameter int MEM_ADDR_W = IDX_W + 1 + LINE_OFS_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic [COLOR_W-1:0]    clearColor,
  output logic [IDX_W-1:0]      auxAddr,
  output logic                  auxRe,
  input  logic [AUX_W-1:0]      auxRdata,
  output logic                  auxWe,
  output logic [AUX_W-1:0]      auxWdata,
  output logic                  memValid,
  input  logic                  memReady,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [LINE_BITS-1:0]  memData
);

  dpCtrl_t ctrl;
  logic    blockClear;
  logic    idxLast;

  fcr_control #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .blockClear(blockClear),
    .idxLast   (idxLast),
    .memReady  (memReady),
    .ctrl      (ctrl),
    .auxRe     (auxRe),
    .auxWe     (auxWe),
    .memValid  (memValid),
    .busy      (busy),
    .done      (done)
  );

  fcr_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .AUX_W     (AUX_W),
    .COLOR_W   (COLOR_W),
    .LINE_BITS (LINE_BITS),
    .IDX_W     (IDX_W),
    .LINE_OFS_W(LINE_OFS_W),
    .MEM_ADDR_W(MEM_ADDR_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .auxRdata  (auxRdata),
    .clearColor(clearColor),
    .blockClear(blockClear),
    .idxLast   (idxLast),
    .auxAddr   (auxAddr),
    .memAddr   (memAddr),
    .memData   (memData)
  );

  // pass-through code
  assign auxWdata = '0;

  // R6: a stalled beat keeps its address and data
  p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memData)));

  // R5: an accepted low line is followed by the high line of the same block
  p_low_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !memAddr[LINE_OFS_W]) |=>
      (memValid && memAddr[LINE_OFS_W] &&
       memAddr[MEM_ADDR_W-1:LINE_OFS_W+1] == $past(memAddr[MEM_ADDR_W-1:LINE_OFS_W+1])));

  // R8: nothing is accessed outside a walk
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memValid || auxWe || auxRe));

endmodule

// File: tb/test_fast_clear_resolver.sv
module test_fast_clear_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- instance A: 8 blocks, 2-bit codes ----------------
  logic         aStart = 1'b0;
  logic         aBusy, aDone, aAuxRe, aAuxWe, aMemValid, aMemReady;
  logic [31:0]  aColor = '0;
  logic [2:0]   aAuxAddr;
  logic [1:0]   aAuxRd, aAuxWd;
  logic [9:0]   aMemAddr;
  logic [511:0] aMemData;
  logic         stallA = 1'b0;

  assign aMemReady = !stallA || (cyc % 3 == 2);

  fast_clear_resolver #(.NUM_BLOCKS(NA), .AUX_W(2)) i_fast_clear_resolver (
    .clk(clk), .rstN(rstN), .start(aStart), .busy(aBusy), .done(aDone),
    .clearColor(aColor), .auxAddr(aAuxAddr), .auxRe(aAuxRe), .auxRdata(aAuxRd),
    .auxWe(aAuxWe), .auxWdata(aAuxWd), .memValid(aMemValid), .memReady(aMemReady),
    .memAddr(aMemAddr), .memData(aMemData));

  logic [1:0]  auxA [NA];
  logic        loadA = 1'b0;
  logic [15:0] loadPatA = '0;
  always @(posedge clk) begin
    if (loadA) begin
      for (int i = 0; i < NA; i++) auxA[i] <= loadPatA[2*i +: 2];
    end else begin
      if (aAuxRe) aAuxRd <= auxA[aAuxAddr];
      if (aAuxWe) auxA[aAuxAddr] <= aAuxWd;
    end
  end

  logic [9:0]   logAddrA [32];
  logic [511:0] logDataA [32];
  int           logCntA = 0;
  int           rdOrderA [16];
  int           rdCntA = 0;
  logic         clrLogA = 1'b0;
  logic         holdPend = 1'b0;
  logic [9:0]   holdAddr = '0;
  logic [511:0] holdData = '0;
  int           holdChecks = 0;
  int           holdErrs = 0;
  always @(posedge clk) begin
    if (clrLogA) begin
      logCntA  = 0;
      rdCntA   = 0;
      holdPend = 1'b0;
    end else begin
      if (aMemValid && aMemReady && logCntA < 32) begin
        logAddrA[logCntA] = aMemAddr;
        logDataA[logCntA] = aMemData;
        logCntA++;
      end
      if (aAuxRe && rdCntA < 16) begin
        rdOrderA[rdCntA] = int'(aAuxAddr);
        rdCntA++;
      end
      if (holdPend) begin
        holdChecks++;
        if (!aMemValid || aMemAddr != holdAddr || aMemData != holdData) begin
          holdErrs++;
          $display("FAIL R6 stalled beat changed: valid=%0b addr=%0h expected addr=%0h",
                   aMemValid, aMemAddr, holdAddr);
        end
      end
      holdPend = aMemValid && !aMemReady;
      holdAddr = aMemAddr;
      holdData = aMemData;
    end
  end

  // ---------------- instance B: 3 blocks, 1-bit codes ----------------
  logic         bStart = 1'b0;
  logic         bBusy, bDone, bAuxRe, bAuxWe, bMemValid;
  logic [31:0]  bColor = '0;
  logic [1:0]   bAuxAddr;
  logic [0:0]   bAuxRd, bAuxWd;
  logic [8:0]   bMemAddr;
  logic [511:0] bMemData;

  fast_clear_resolver #(.NUM_BLOCKS(NB), .AUX_W(1)) i_fast_clear_resolver_b (
    .clk(clk), .rstN(rstN), .start(bStart), .busy(bBusy), .done(bDone),
    .clearColor(bColor), .auxAddr(bAuxAddr), .auxRe(bAuxRe), .auxRdata(bAuxRd),
    .auxWe(bAuxWe), .auxWdata(bAuxWd), .memValid(bMemValid), .memReady(1'b1),
    .memAddr(bMemAddr), .memData(bMemData));

  logic [0:0] auxB [4];
  logic       loadB = 1'b0;
  logic [2:0] loadPatB = '0;
  always @(posedge clk) begin
    if (loadB) begin
      for (int i = 0; i < NB; i++) auxB[i] <= loadPatB[i];
    end else begin
      if (bAuxRe) bAuxRd <= auxB[bAuxAddr];
      if (bAuxWe) auxB[bAuxAddr] <= bAuxWd;
    end
  end

  logic [8:0]   logAddrB [8];
  logic [511:0] logDataB [8];
  int           logCntB = 0;
  always @(posedge clk) begin
    if (loadB) logCntB = 0;
    else if (bMemValid && logCntB < 8) begin
      logAddrB[logCntB] = bMemAddr;
      logDataB[logCntB] = bMemData;
      logCntB++;
    end
  end

  // ---------------- instance C: empty surface ----------------
  logic         cStart = 1'b0;
  logic         cBusy, cDone, cAuxRe, cAuxWe, cMemValid;
  logic [0:0]   cAuxAddr;
  logic [1:0]   cAuxWd;
  logic [7:0]   cMemAddr;
  logic [511:0] cMemData;

  fast_clear_resolver #(.NUM_BLOCKS(0), .AUX_W(2)) i_fast_clear_resolver_c (
    .clk(clk), .rstN(rstN), .start(cStart), .busy(cBusy), .done(cDone),
    .clearColor(32'h0), .auxAddr(cAuxAddr), .auxRe(cAuxRe), .auxRdata(2'b11),
    .auxWe(cAuxWe), .auxWdata(cAuxWd), .memValid(cMemValid), .memReady(1'b1),
    .memAddr(cMemAddr), .memData(cMemData));

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one walk on instance A
  task automatic runA(input logic [15:0] pat, input logic [31:0] color,
                      input bit stall, input bit extraStart, input string tag);
    int expCnt;
    int cycles;
    int logAfter;
    bit prevWe;
    bit seenDone;
    logic [511:0] expData;
    @(negedge clk);
    stallA   = stall;
    loadPatA = pat;
    loadA    = 1'b1;
    clrLogA  = 1'b1;
    aColor   = color;
    @(negedge clk);
    loadA   = 1'b0;
    clrLogA = 1'b0;
    aStart  = 1'b1;
    @(negedge clk);
    aStart = 1'b0;
    check(aBusy == 1'b1, "R7", {tag, " busy after start"}, aBusy, 1);
    aColor = ~color;  // R9: must not affect the data
    cycles   = 0;
    prevWe   = 1'b0;
    seenDone = 1'b0;
    while (!seenDone && cycles < 3000) begin
      if (extraStart && cycles == 9) aStart = 1'b1;
      else aStart = 1'b0;
      prevWe = aAuxWe;
      @(negedge clk);
      cycles++;
      if (aDone) seenDone = 1'b1;
    end
    aStart = 1'b0;
    check(seenDone, "R7", {tag, " done seen"}, seenDone, 1);
    check(prevWe, "R7", {tag, " done right after last aux write"}, prevWe, 1);
    @(negedge clk);
    check(!aDone && !aBusy, "R7", {tag, " done one cycle, then idle"},
          {aDone, aBusy}, 0);
    logAfter = logCntA;
    repeat (30) @(negedge clk);
    check(!aBusy && logCntA == logAfter, "R8", {tag, " no second walk"},
          logCntA, logAfter);
    // expected writes
    expData = {16{color}};
    expCnt  = 0;
    for (int i = 0; i < NA; i++) if (pat[2*i +: 2] == 2'b11) expCnt += 2;
    check(logCntA == expCnt, "R2", {tag, " write beat count (R3)"}, logCntA, expCnt);
    begin
      int k = 0;
      for (int i = 0; i < NA; i++) begin
        if (pat[2*i +: 2] == 2'b11 && k + 1 < logCntA) begin
          check(logAddrA[k] == 10'(i*128), "R5", {tag, " low line address"},
                logAddrA[k], i*128);
          check(logAddrA[k+1] == 10'(i*128 + 64), "R5", {tag, " high line address"},
                logAddrA[k+1], i*128 + 64);
          check(logDataA[k] == expData && logDataA[k+1] == expData, "R9",
                {tag, " line data is latched color (R2)"}, logDataA[k][31:0], color);
          k += 2;
        end
      end
    end
    check(rdCntA == NA, "R1", {tag, " aux read count"}, rdCntA, NA);
    begin
      bit inOrder = 1'b1;
      for (int i = 0; i < NA && i < rdCntA; i++) if (rdOrderA[i] != i) inOrder = 1'b0;
      check(inOrder, "R1", {tag, " ascending read order"}, inOrder, 1);
    end
    begin
      bit allZero = 1'b1;
      for (int i = 0; i < NA; i++) if (auxA[i] != 2'b00) allZero = 1'b0;
      check(allZero, "R4", {tag, " aux store all pass-through (R11)"}, allZero, 1);
    end
  endtask

  task automatic testReset();
    check(!aBusy && !aDone && !aMemValid && !aAuxRe && !aAuxWe, "R7",
          "reset state idle", {aBusy, aDone, aMemValid, aAuxRe, aAuxWe}, 0);
  endtask

  task automatic testOneBit();
    int cycles = 0;
    logic [511:0] expData;
    @(negedge clk);
    loadPatB = 3'b101;
    loadB    = 1'b1;
    bColor   = 32'hA5C3_0F96;
    @(negedge clk);
    loadB  = 1'b0;
    bStart = 1'b1;
    @(negedge clk);
    bStart = 1'b0;
    while (!bDone && cycles < 500) begin
      @(negedge clk);
      cycles++;
    end
    @(negedge clk);
    expData = {16{32'hA5C3_0F96}};
    check(logCntB == 4, "R2", "1-bit mode beat count", logCntB, 4);
    check(logAddrB[0] == 9'd0 && logAddrB[1] == 9'd64, "R5",
          "1-bit mode block 0 addresses", {logAddrB[0], logAddrB[1]}, 64);
    check(logAddrB[2] == 9'd256 && logAddrB[3] == 9'd320, "R5",
          "1-bit mode block 2 addresses", {logAddrB[2], logAddrB[3]}, {9'd256, 9'd320});
    check(logDataB[0] == expData && logDataB[3] == expData, "R2",
          "1-bit mode line data", logDataB[0][31:0], 32'hA5C3_0F96);
    check(auxB[0] == 1'b0 && auxB[1] == 1'b0 && auxB[2] == 1'b0, "R4",
          "1-bit mode aux cleared", {auxB[0], auxB[1], auxB[2]}, 0);
  endtask

  task automatic testEmpty();
    bit sawAccess = 1'b0;
    @(negedge clk);
    cStart = 1'b1;
    @(negedge clk);
    cStart = 1'b0;
    check(cDone == 1'b1, "R10", "empty surface done next cycle", cDone, 1);
    sawAccess = cAuxRe || cAuxWe || cMemValid;
    @(negedge clk);
    check(!cDone && !cBusy, "R10", "empty surface back to idle", {cDone, cBusy}, 0);
    check(!sawAccess, "R10", "empty surface makes no access", sawAccess, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors",
             checks + holdChecks + 1, errors + holdErrs + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // all blocks clear, no backpressure
    runA(16'hFFFF, 32'h1234_5678, 1'b0, 1'b0, "all-clear");
    // mixed codes with heavy backpressure (R3, R6, R11)
    runA({2'b11, 2'b11, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11},
         32'hDEAD_BEEF, 1'b1, 1'b0, "mixed-stall");
    // nothing clear: only aux rewrites (R3, R11)
    runA({2'b10, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 2'b01},
         32'h0BAD_F00D, 1'b0, 1'b0, "none-clear");
    // stray start while busy under backpressure (R8)
    runA({2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00},
         32'h5555_AAAA, 1'b1, 1'b1, "restart-ignored");
    testOneBit();
    testEmpty();
    check(holdChecks > 0, "R6", "stall cycles exercised", holdChecks, 1);
    $display("Simulation finished: %0d checks, %0d errors",
             checks + holdChecks, errors + holdErrs);
    $finish;
  end

endmodule